// File: doc/BRIEF.md
# Integer Multiply, Multiply-Accumulate and Divide Unit

This block is a free-running 32-bit integer arithmetic engine that sits beside an integer pipeline. It holds a 64-bit result pair, a high word and a low word, and accepts one operation at a time through a start strobe with an opcode and two operands. It runs signed and unsigned multiplies that fill the pair, multiply-accumulates that add a product onto the pair, a three-operand multiply that returns only the low product word on a separate register-file result port, and signed and unsigned divides that leave the quotient in the low word and the remainder in the high word.

Multiply timing follows the width of the operands. When both operands fit in a half word the product lands earlier and the next operation may issue sooner. A divide always takes the same number of cycles. The issuing pipeline learns when to wait through a stall output. Stall rises for a start that cannot be taken yet, for a read of the result pair while an operation is still in flight, and for a short window after a three-operand multiply. The result pair is read through two request inputs that steer one read-data output.

Top module: `mdu_core`

## Requirements
- R1: After reset the high and low words read as zero, and busy, stall and gpr_valid are low.
- R2: A multiply whose operands are both half-word sized writes its result 3 cycles after the accepting clock edge, and the unit takes a new start 2 cycles after that edge.
- R3: A multiply with any operand wider than a half word writes its result 4 cycles after the accepting edge, and the unit takes a new start 3 cycles after that edge.
- R4: Opcodes are 0 signed multiply, 1 unsigned multiply, 2 signed multiply-accumulate, 3 unsigned multiply-accumulate, 4 three-operand signed multiply, 5 signed divide, 6 unsigned divide; code 7 is ignored and changes nothing. A signed operand counts as half-word sized when bits 31 to 15 are all equal, an unsigned operand when bits 31 to 16 are zero. Multiplies put the full 64-bit product in high:low.
- R5: A multiply-accumulate adds its 64-bit product, modulo 2^64, to the high:low contents present when it completes, with the timing of R2 and R3.
- R6: The three-operand multiply presents the low 32 bits of the signed product on gpr_data with a one-cycle gpr_valid pulse at the R2/R3 latency, and leaves the high and low words unchanged.
- R7: After the edge that accepts a three-operand multiply, stall is high for 1 cycle with half-word operands and 2 cycles otherwise; other opcodes add no such stall.
- R8: A divide writes quotient to low and remainder to high 36 cycles after the accepting edge and the unit takes a new start 36 cycles after that edge; the quotient truncates toward zero, the remainder has the dividend's sign, and signed 0x80000000 divided by -1 gives quotient 0x80000000 and remainder 0.
- R9: A divide by zero completes in the same 36 cycles with quotient 0xFFFFFFFF and the raw dividend as remainder.
- R10: busy is high from the accepting edge until a new start may be taken; a start while busy raises stall in that cycle and is not taken until busy falls.
- R11: rd_data shows the high word when rd_hi is set, else the low word when rd_lo is set, else zero; a read request while any operation is in flight raises stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin an operation |
| op | input | 3 | Opcode, encoding in R4 |
| opa | input | 32 | First operand, dividend for divides |
| opb | input | 32 | Second operand, divisor for divides |
| rd_hi | input | 1 | Read request for the high word |
| rd_lo | input | 1 | Read request for the low word |
| busy | output | 1 | New starts cannot be taken this cycle |
| stall | output | 1 | Issuing pipeline must hold this cycle |
| gpr_valid | output | 1 | One-cycle pulse with a three-operand multiply result |
| gpr_data | output | 32 | Low product word of the last three-operand multiply |
| rd_data | output | 32 | Selected result word |

## Verification
Counting from the rising edge that accepts a start, the high:low pair and the gpr pulse change on edge 3 for half-word multiplies, edge 4 for wide ones and edge 36 for divides, while busy falls so that the next start is taken on edge 2, 3 or 36. The three-operand stall covers the first one or two cycles after acceptance, and the read and start stalls follow their inputs in the same cycle. The bench keeps a behavioural model that counts each in-flight result down from its latency and commits it in order. It compares busy, stall, gpr_valid, gpr_data and rd_data against that model on every falling edge, so any result a cycle early or late shows up as a mismatch. Stimulus holds start or a read request until the model says it is taken, which drives back-to-back issue at exactly the repeat interval.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [2:0] {
    OP_MULS = 3'd0,
    OP_MULU = 3'd1,
    OP_MACS = 3'd2,
    OP_MACU = 3'd3,
    OP_MUL3 = 3'd4,
    OP_DIVS = 3'd5,
    OP_DIVU = 3'd6,
    OP_NONE = 3'd7
  } mdu_op_e;

  typedef enum logic [1:0] {
    WB_HILO = 2'd0,
    WB_ACC  = 2'd1,
    WB_GPR  = 2'd2
  } wb_kind_e;

endpackage

// File: rtl/mdu_opclass.sv
module mdu_opclass
  import mdu_pkg::*;
#(
  parameter int XLEN         = 32,
  parameter int LAT_NARROW   = 3,
  parameter int LAT_WIDE     = 4,
  parameter int REP_NARROW   = 2,
  parameter int REP_WIDE     = 3,
  parameter int STALL_NARROW = 1,
  parameter int STALL_WIDE   = 2,
  parameter int DIV_CYCLES   = 36,
  parameter int LW           = 3,
  parameter int CW           = 6
) (
  input  mdu_op_e               op,
  input  logic [XLEN-1:0]       a,
  input  logic [XLEN-1:0]       b,
  output logic                  is_mul,
  output logic                  is_div,
  output logic                  sgn,
  output logic [LW-1:0]         lat,
  output logic [CW-1:0]         rep,
  output logic [CW-1:0]         stl,
  output wb_kind_e              kind,
  output logic [2*XLEN-1:0]     prod
);

  localparam int HALF = XLEN / 2;

  function automatic logic fits_half(input logic [XLEN-1:0] v, input logic s);
    logic [XLEN-HALF:0] upper;
    upper = v[XLEN-1:HALF-1];
    if (s) return (&upper) || (~|upper);
    return ~|v[XLEN-1:HALF];
  endfunction

  function automatic logic [2*XLEN-1:0] full_product(input logic [XLEN-1:0] x,
                                                     input logic [XLEN-1:0] y,
                                                     input logic s);
    logic [2*XLEN-1:0] ex, ey;
    ex = s ? {{XLEN{x[XLEN-1]}}, x} : {{XLEN{1'b0}}, x};
    ey = s ? {{XLEN{y[XLEN-1]}}, y} : {{XLEN{1'b0}}, y};
    return ex * ey;
  endfunction

  logic narrow;

  always_comb begin
    is_div = (op == OP_DIVS) || (op == OP_DIVU);
    is_mul = op inside {OP_MULS, OP_MULU, OP_MACS, OP_MACU, OP_MUL3};
    sgn    = op inside {OP_MULS, OP_MACS, OP_MUL3, OP_DIVS};
    narrow = fits_half(a, sgn) && fits_half(b, sgn);
    kind   = WB_HILO;
    if (op == OP_MACS || op == OP_MACU) kind = WB_ACC;
    if (op == OP_MUL3) kind = WB_GPR;
    lat    = narrow ? LW'(LAT_NARROW) : LW'(LAT_WIDE);
    if (is_div)      rep = CW'(DIV_CYCLES);
    else if (narrow) rep = CW'(REP_NARROW);
    else             rep = CW'(REP_WIDE);
    if (op == OP_MUL3) stl = narrow ? CW'(STALL_NARROW) : CW'(STALL_WIDE);
    else               stl = '0;
    prod   = full_product(a, b, sgn);
  end

endmodule

// File: rtl/mdu_mulpipe.sv
module mdu_mulpipe
  import mdu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int DEPTH = 4,
  parameter int LW    = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push,
  input  logic [LW-1:0]         push_lat,
  input  wb_kind_e              push_kind,
  input  logic [2*XLEN-1:0]     push_prod,
  output logic                  pop_valid,
  output wb_kind_e              pop_kind,
  output logic [2*XLEN-1:0]     pop_prod,
  output logic                  any_valid
);

  typedef struct packed {
    logic              v;
    wb_kind_e          k;
    logic [2*XLEN-1:0] p;
  } slot_t;

  slot_t slot [DEPTH];
  slot_t shifted [DEPTH];

  // each slot moves one place toward the head per cycle
  for (genvar i = 0; i < DEPTH; i++) begin : g_shift
    if (i < DEPTH - 1) begin : g_mid
      assign shifted[i] = slot[i+1];
    end else begin : g_tail
      assign shifted[i] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (push && push_lat == LW'(i + 1)) begin
          slot[i] <= '{v: 1'b1, k: push_kind, p: push_prod};
        end else begin
          slot[i] <= shifted[i];
        end
      end
    end
  end

  always_comb begin
    any_valid = 1'b0;
    for (int i = 0; i < DEPTH; i++) any_valid = any_valid | slot[i].v;
  end

  assign pop_valid = slot[0].v;
  assign pop_kind  = slot[0].k;
  assign pop_prod  = slot[0].p;

endmodule

// File: rtl/mdu_divseq.sv
module mdu_divseq #(
  parameter int XLEN       = 32,
  parameter int DIV_CYCLES = 36,
  parameter int CW         = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic            sgn,
  input  logic [XLEN-1:0] dividend,
  input  logic [XLEN-1:0] divisor,
  output logic            active,
  output logic            done,
  output logic [XLEN-1:0] quo,
  output logic [XLEN-1:0] rem
);

  localparam int STEP_FLOOR = DIV_CYCLES - XLEN;

  logic [CW-1:0]   cnt;
  logic            neg_q, neg_r, by_zero;
  logic [XLEN-1:0] dvd_raw, dvs_mag, q_sh, r_acc;
  logic [XLEN:0]   trial;
  logic            stepping;

  function automatic logic [XLEN-1:0] magnitude(input logic [XLEN-1:0] v, input logic s);
    return (s && v[XLEN-1]) ? (~v + 1'b1) : v;
  endfunction

  assign stepping = active && (cnt >= CW'(STEP_FLOOR));
  assign trial    = {r_acc, q_sh[XLEN-1]} - {1'b0, dvs_mag};
  assign done     = active && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      cnt     <= '0;
      neg_q   <= 1'b0;
      neg_r   <= 1'b0;
      by_zero <= 1'b0;
      dvd_raw <= '0;
      dvs_mag <= '0;
      q_sh    <= '0;
      r_acc   <= '0;
    end else if (go) begin
      active  <= 1'b1;
      cnt     <= CW'(DIV_CYCLES - 1);
      neg_q   <= sgn && (dividend[XLEN-1] ^ divisor[XLEN-1]);
      neg_r   <= sgn && dividend[XLEN-1];
      by_zero <= (divisor == '0);
      dvd_raw <= dividend;
      dvs_mag <= magnitude(divisor, sgn);
      q_sh    <= magnitude(dividend, sgn);
      r_acc   <= '0;
    end else if (active) begin
      cnt <= cnt - 1'b1;
      if (done) active <= 1'b0;
      if (stepping) begin
        if (!trial[XLEN]) begin
          r_acc <= trial[XLEN-1:0];
          q_sh  <= {q_sh[XLEN-2:0], 1'b1};
        end else begin
          r_acc <= {r_acc[XLEN-2:0], q_sh[XLEN-1]};
          q_sh  <= {q_sh[XLEN-2:0], 1'b0};
        end
      end
    end
  end

  always_comb begin
    if (by_zero) begin
      quo = '1;
      rem = dvd_raw;
    end else begin
      quo = neg_q ? (~q_sh + 1'b1) : q_sh;
      rem = neg_r ? (~r_acc + 1'b1) : r_acc;
    end
  end

endmodule

// File: rtl/mdu_core.sv
module mdu_core
  import mdu_pkg::*;
#(
  parameter int XLEN         = 32,
  parameter int LAT_NARROW   = 3,
  parameter int LAT_WIDE     = 4,
  parameter int REP_NARROW   = 2,
  parameter int REP_WIDE     = 3,
  parameter int STALL_NARROW = 1,
  parameter int STALL_WIDE   = 2,
  parameter int DIV_CYCLES   = 36
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [2:0]      op,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic            rd_hi,
  input  logic            rd_lo,
  output logic            busy,
  output logic            stall,
  output logic            gpr_valid,
  output logic [XLEN-1:0] gpr_data,
  output logic [XLEN-1:0] rd_data
);

  localparam int CW = $clog2(DIV_CYCLES + 1);
  localparam int LW = $clog2(LAT_WIDE + 1);

  mdu_op_e           op_e;
  logic              is_mul, is_div, sgn;
  logic [LW-1:0]     lat;
  logic [CW-1:0]     rep, stl;
  wb_kind_e          kind;
  logic [2*XLEN-1:0] prod;

  logic [CW-1:0]     rep_cnt, mst_cnt;
  logic [XLEN-1:0]   hi_q, lo_q;

  logic              ev_accept, ev_issue_mul, ev_issue_div, ev_mul3_issue;
  logic              ev_pending, ev_div_done;
  logic              pop_valid, pipe_busy, div_active;
  wb_kind_e          pop_kind;
  logic [2*XLEN-1:0] pop_prod;
  logic [XLEN-1:0]   div_q, div_r;

  assign op_e = mdu_op_e'(op);

  mdu_opclass #(
    .XLEN(XLEN), .LAT_NARROW(LAT_NARROW), .LAT_WIDE(LAT_WIDE),
    .REP_NARROW(REP_NARROW), .REP_WIDE(REP_WIDE),
    .STALL_NARROW(STALL_NARROW), .STALL_WIDE(STALL_WIDE),
    .DIV_CYCLES(DIV_CYCLES), .LW(LW), .CW(CW)
  ) u_class (
    .op(op_e), .a(opa), .b(opb),
    .is_mul(is_mul), .is_div(is_div), .sgn(sgn),
    .lat(lat), .rep(rep), .stl(stl), .kind(kind), .prod(prod)
  );

  assign busy          = (rep_cnt != '0);
  assign ev_accept     = start && !busy && (op_e != OP_NONE);
  assign ev_issue_mul  = ev_accept && is_mul;
  assign ev_issue_div  = ev_accept && is_div;
  assign ev_mul3_issue = ev_accept && (op_e == OP_MUL3);

  mdu_mulpipe #(.XLEN(XLEN), .DEPTH(LAT_WIDE), .LW(LW)) u_pipe (
    .clk(clk), .rst_n(rst_n),
    .push(ev_issue_mul), .push_lat(lat), .push_kind(kind), .push_prod(prod),
    .pop_valid(pop_valid), .pop_kind(pop_kind), .pop_prod(pop_prod),
    .any_valid(pipe_busy)
  );

  mdu_divseq #(.XLEN(XLEN), .DIV_CYCLES(DIV_CYCLES), .CW(CW)) u_div (
    .clk(clk), .rst_n(rst_n),
    .go(ev_issue_div), .sgn(sgn), .dividend(opa), .divisor(opb),
    .active(div_active), .done(ev_div_done), .quo(div_q), .rem(div_r)
  );

  assign ev_pending = pipe_busy || div_active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rep_cnt <= '0;
      mst_cnt <= '0;
    end else begin
      if (ev_accept)          rep_cnt <= rep - CW'(1);
      else if (rep_cnt != '0) rep_cnt <= rep_cnt - CW'(1);
      if (ev_mul3_issue)      mst_cnt <= stl;
      else if (mst_cnt != '0) mst_cnt <= mst_cnt - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q      <= '0;
      lo_q      <= '0;
      gpr_data  <= '0;
      gpr_valid <= 1'b0;
    end else begin
      gpr_valid <= 1'b0;
      if (pop_valid) begin
        case (pop_kind)
          WB_HILO: {hi_q, lo_q} <= pop_prod;
          WB_ACC:  {hi_q, lo_q} <= {hi_q, lo_q} + pop_prod;
          WB_GPR: begin
            gpr_data  <= pop_prod[XLEN-1:0];
            gpr_valid <= 1'b1;
          end
          default: ;
        endcase
      end
      if (ev_div_done) begin
        hi_q <= div_r;
        lo_q <= div_q;
      end
    end
  end

  assign stall   = (start && busy) || ((rd_hi || rd_lo) && ev_pending) || (mst_cnt != '0);
  assign rd_data = rd_hi ? hi_q : (rd_lo ? lo_q : '0);

endmodule

// File: rtl/mdu_core_chk.sv
module mdu_core_chk #(
  parameter int XLEN       = 32,
  parameter int DIV_CYCLES = 36
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            stall,
  input logic            rd_hi,
  input logic            rd_lo,
  input logic            ev_issue_mul,
  input logic            ev_issue_div,
  input logic            ev_div_done,
  input logic            ev_pending,
  input logic            ev_mul3_issue,
  input logic            gpr_valid,
  input logic [XLEN-1:0] hi_q,
  input logic [XLEN-1:0] lo_q
);

  localparam int AW = $clog2(DIV_CYCLES + 2);

  logic [AW-1:0] div_age;

  always_ff @(posedge clk) begin
    if (!rst_n)                                div_age <= '0;
    else if (ev_issue_div)                     div_age <= AW'(1);
    else if (div_age != '0 && div_age <= AW'(DIV_CYCLES)) div_age <= div_age + AW'(1);
  end

  // R10
  start_busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |-> stall);

  // R11
  read_pending_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_hi || rd_lo) && ev_pending) |-> stall);

  // R6
  mul3_keeps_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gpr_valid |-> ($stable(hi_q) && $stable(lo_q)));

  // R7
  mul3_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mul3_issue |=> stall);

  // R10
  issue_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_issue_mul || ev_issue_div) |=> busy);

  // R8
  div_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_div_done |-> (div_age == AW'(DIV_CYCLES)));

  // R8
  div_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_age != '0 && div_age < AW'(DIV_CYCLES)) |-> busy);

endmodule

bind mdu_core mdu_core_chk #(.XLEN(XLEN), .DIV_CYCLES(DIV_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .stall(stall),
  .rd_hi(rd_hi), .rd_lo(rd_lo),
  .ev_issue_mul(ev_issue_mul), .ev_issue_div(ev_issue_div),
  .ev_div_done(ev_div_done), .ev_pending(ev_pending),
  .ev_mul3_issue(ev_mul3_issue), .gpr_valid(gpr_valid),
  .hi_q(hi_q), .lo_q(lo_q)
);

// File: tb/mdu_core_bench.sv
module mdu_core_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [31:0] opa = '0, opb = '0;
  logic        rd_hi = 1'b0, rd_lo = 1'b0;
  logic        busy, stall, gpr_valid;
  logic [31:0] gpr_data, rd_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdu_core u_mdu_core (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
    .rd_hi(rd_hi), .rd_lo(rd_lo), .busy(busy), .stall(stall),
    .gpr_valid(gpr_valid), .gpr_data(gpr_data), .rd_data(rd_data)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  string tag     = "R1";

  typedef struct {
    int          rem;
    int          kind;
    logic [63:0] val;
  } ent_t;

  ent_t        q[$];
  int          m_rep, m_mst;
  logic [31:0] m_hi, m_lo, m_gpr;
  bit          m_gv;

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit fits16(input logic [31:0] v, input bit s);
    if (s) return ($signed(v) >= -32768) && ($signed(v) <= 32767);
    return v < 32'd65536;
  endfunction

  function automatic logic [63:0] mulref(input logic [31:0] a, input logic [31:0] b, input bit s);
    longint p;
    if (s) begin
      p = longint'($signed(a)) * longint'($signed(b));
      return p;
    end
    return {32'h0, a} * {32'h0, b};
  endfunction

  function automatic logic [63:0] divref(input logic [31:0] a, input logic [31:0] b, input bit s);
    int sa, sb;
    if (b == 0) return {a, 32'hFFFF_FFFF};
    if (!s) return {a % b, a / b};
    if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return {32'h0, a};
    sa = a;
    sb = b;
    return {32'(sa % sb), 32'(sa / sb)};
  endfunction

  // behavioural reference: each result counts down from its latency
  always @(posedge clk) begin : mdl
    ent_t e;
    bit   nar, sg;
    if (!rst_n) begin
      q.delete();
      m_rep = 0; m_mst = 0;
      m_hi = 0; m_lo = 0; m_gpr = 0; m_gv = 0;
    end else begin
      m_gv = 0;
      foreach (q[i]) q[i].rem--;
      if (q.size() > 0 && q[0].rem == 0) begin
        case (q[0].kind)
          0: {m_hi, m_lo} = q[0].val;
          1: {m_hi, m_lo} = {m_hi, m_lo} + q[0].val;
          default: begin m_gpr = q[0].val[31:0]; m_gv = 1; end
        endcase
        void'(q.pop_front());
      end
      if (start && m_rep == 0 && op != 3'd7) begin
        sg  = (op == 3'd0) || (op == 3'd2) || (op == 3'd4) || (op == 3'd5);
        nar = fits16(opa, sg) && fits16(opb, sg);
        if (op >= 3'd5) begin
          e.rem = 36; e.kind = 0; e.val = divref(opa, opb, sg);
          m_rep = 35;
        end else begin
          e.rem  = nar ? 3 : 4;
          e.kind = (op == 3'd2 || op == 3'd3) ? 1 : ((op == 3'd4) ? 2 : 0);
          e.val  = mulref(opa, opb, sg);
          m_rep  = nar ? 1 : 2;
        end
        q.push_back(e);
        if (op == 3'd4) m_mst = nar ? 1 : 2;
        else if (m_mst > 0) m_mst--;
      end else begin
        if (m_rep > 0) m_rep--;
        if (m_mst > 0) m_mst--;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("busy", 64'(busy), 64'(m_rep != 0));
      chk("stall", 64'(stall),
          64'((start && m_rep != 0) || ((rd_hi || rd_lo) && q.size() > 0) || m_mst != 0));
      chk("gpr_valid", 64'(gpr_valid), 64'(m_gv));
      chk("gpr_data", 64'(gpr_data), 64'(m_gpr));
      chk("rd_data", 64'(rd_data), 64'(rd_hi ? m_hi : (rd_lo ? m_lo : 32'h0)));
    end
  end

  task automatic issue(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b);
    start = 1'b1; op = o; opa = a; opb = b;
    do @(negedge clk); while (m_rep != 0);
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic rd(input bit hi);
    rd_hi = hi; rd_lo = !hi;
    do @(negedge clk); while (q.size() != 0);
    @(posedge clk); #1;
    rd_hi = 1'b0; rd_lo = 1'b0;
  endtask

  task automatic rd_pair();
    rd(1'b1);
    rd(1'b0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    tag = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("busy in reset", 64'(busy), 64'd0);
    chk("stall in reset", 64'(stall), 64'd0);
    chk("gpr_valid in reset", 64'(gpr_valid), 64'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    rd_hi = 1'b1;
    @(negedge clk);
    chk("hi after reset", 64'(rd_data), 64'd0);
    @(posedge clk); #1;
    rd_hi = 1'b0; rd_lo = 1'b1;
    @(negedge clk);
    chk("lo after reset", 64'(rd_data), 64'd0);
    @(posedge clk); #1;
    rd_lo = 1'b0;

    tag = "R2";
    issue(3'd0, 32'd3, 32'hFFFF_FFFB);
    rd_pair();
    issue(3'd1, 32'd100, 32'd200);
    issue(3'd1, 32'd7, 32'd9);
    issue(3'd0, 32'hFFFF_8000, 32'h0000_7FFF);
    rd_pair();

    tag = "R3";
    issue(3'd0, 32'h1234_5678, 32'hFFFF_FFFD);
    rd_pair();
    issue(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    issue(3'd0, 32'h0001_0000, 32'd2);
    issue(3'd1, 32'd5, 32'h8000_0000);
    rd_pair();

    tag = "R4";
    issue(3'd1, 32'h0000_FFFF, 32'h0000_FFFF);
    issue(3'd0, 32'h0000_FFFF, 32'd1);
    issue(3'd1, 32'hFFFF_8000, 32'd1);
    rd_pair();
    issue(3'd7, 32'd11, 32'd13);
    idle(5);
    rd_pair();

    tag = "R5";
    issue(3'd0, 32'd10, 32'd20);
    issue(3'd2, 32'hFFFF_FFFD, 32'd4);
    issue(3'd2, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    rd_pair();
    issue(3'd3, 32'hFFFF_FFFF, 32'd2);
    issue(3'd3, 32'd3, 32'd3);
    rd_pair();

    tag = "R6 R7";
    issue(3'd4, 32'd300, 32'hFFFF_FFF9);
    idle(4);
    issue(3'd4, 32'h0123_4567, 32'h89AB_CDEF);
    idle(5);
    rd_pair();
    issue(3'd4, 32'd2, 32'd3);
    issue(3'd0, 32'd6, 32'd7);
    rd_pair();

    tag = "R8";
    issue(3'd5, 32'hFFFF_FFF9, 32'd2);
    rd_pair();
    issue(3'd6, 32'd100, 32'd7);
    rd_pair();
    issue(3'd5, 32'd7, 32'hFFFF_FFFE);
    rd_pair();
    issue(3'd5, 32'h8000_0000, 32'hFFFF_FFFF);
    rd_pair();
    issue(3'd6, 32'hFFFF_FFFF, 32'h0001_0000);
    rd_pair();

    tag = "R9";
    issue(3'd5, 32'd5, 32'd0);
    rd_pair();
    issue(3'd6, 32'hFFFF_FFF0, 32'd0);
    rd_pair();
    issue(3'd5, 32'hFFFF_FFFB, 32'd0);
    rd_pair();

    tag = "R10";
    issue(3'd6, 32'd1000, 32'd3);
    issue(3'd0, 32'd4, 32'd4);
    issue(3'd1, 32'h0002_0000, 32'd3);
    issue(3'd5, 32'd9, 32'd2);
    rd_pair();

    tag = "R11";
    issue(3'd0, 32'h0000_1234, 32'h0000_0010);
    rd(1'b1);
    issue(3'd6, 32'd50, 32'd8);
    rd(1'b0);
    rd(1'b1);
    idle(3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule